// File: doc/BRIEF.md
# Page-Size-Aware Stride Prefetcher

This block sits beside a second-level cache and watches the stream of demand accesses. Each access arrives as a physical line address (64-byte lines) together with a one-bit page-size tag that travelled with the miss request from the first-level cache. From this the block works out how large a region it may reason about. It uses a 64-line region (4KB) for ordinary pages. It uses a 32768-line region (2MB) when the access lies in a huge page and a configuration input permits the large granularity.

A direct-mapped table of 64 entries is indexed by the low bits of the region number. Each entry remembers the last line offset seen in its region, the last delta between offsets, and a two-bit confidence count. Once the same nonzero delta has been seen often enough, the block emits up to two prefetch line addresses, one and two deltas ahead. It drops any candidate that would leave the active region. Prefetches leave on a valid/ready port.

Because huge-page accesses are tracked per 2MB region, a stride that walks across many 4KB frames trains one entry. Its prefetches may then cross 4KB boundaries freely.

Top module: `ps_spatial_prefetch`

## Requirements
- R1: After reset, `pf_valid` is 0 and the table holds no valid entry.
- R2: The effective granularity is 2MB only when `acc_huge` is 1 and `gran_sel` is 1; in every other combination the access is treated as 4KB. A tag of 1 with `gran_sel` 0 is clamped to the 4KB page.
- R3: A region seen for the first time allocates an entry with stored delta 0 and confidence 0 and emits nothing. With a constant nonzero stride, the fourth access to the region is the first one that emits prefetches. Confidence rises by 1 on a delta match, saturates at 3, and prefetches are issued when the updated confidence is 2 or more.
- R4: A triggering access at offset o with delta d presents the candidate at o+d first and the candidate at o+2d second. Each is formed as the region base plus the candidate offset.
- R5: At 4KB granularity no prefetch leaves the 64-line page of the triggering access. A candidate with offset below 0 or above 63 is dropped.
- R6: At 2MB granularity prefetches may cross 4KB boundaries but not the 32768-line region. A candidate with offset below 0 or above 32767 is dropped.
- R7: At 2MB granularity the region offset is line address bits [14:0], so accesses in different 4KB frames of one 2MB region train a single entry.
- R8: Each entry records the granularity it was trained with. An access that selects the same index and tag under the other granularity is a miss and reallocates the entry.
- R9: An access whose offset equals the stored last offset of a matching entry leaves the entry unchanged and emits nothing.
- R10: A nonzero delta different from the stored delta resets confidence to 0 and stores the new delta, so two further matching accesses are needed before prefetching resumes.
- R11: While `pf_valid` is 1 and `pf_ready` is 0, `pf_line` holds steady. A new triggering access replaces any prefetches not yet accepted.
- R12: The index is line bits [11:6] (4KB) or [20:15] (2MB), and an 8-bit partial tag is taken from the bits just above the index. A tag mismatch at the same index reallocates the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A demand access is presented this cycle |
| acc_line | input | 34 | Physical line address of the access |
| acc_huge | input | 1 | Page-size tag: 0 for 4KB page, 1 for 2MB page |
| gran_sel | input | 1 | 1 permits 2MB granularity for huge-page accesses |
| pf_valid | output | 1 | A prefetch line address is offered |
| pf_ready | input | 1 | Downstream accepts the offered prefetch |
| pf_line | output | 34 | Prefetch line address |

## Verification
The hardest situation to reach is one where a single table entry is shared across granularities. An entry trained in 2MB mode must be met by a 4KB access whose index and tag land on the same slot. That access must also continue the old stride, so that a missing granularity check would show up as a spurious prefetch. The stimulus builds this case from a 2MB line and a 4KB line. The 2MB line has region number 3 in bits [28:21] and 5 in bits [20:15]. The 4KB line carries the same values in bits [19:12] and [11:6], and its offset is chosen to extend the stride. Boundary clamping is reached by placing strides so that one candidate falls just inside a region and the other just outside. Both 4KB and 2MB regions are covered, as is a negative stride.

// File: rtl/ps_spatial_prefetch.sv
module ps_spatial_prefetch #(
  parameter int LA_W      = 34,
  parameter int SMALL_OFF = 6,
  parameter int HUGE_OFF  = 15,
  parameter int IDX_W     = 6,
  parameter int TAG_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [LA_W-1:0] acc_line,
  input  logic            acc_huge,
  input  logic            gran_sel,
  output logic            pf_valid,
  input  logic            pf_ready,
  output logic [LA_W-1:0] pf_line
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int DLT_W   = HUGE_OFF + 1;
  localparam int CW      = DLT_W + 2;

  logic             t_vld  [ENTRIES];
  logic             t_gran [ENTRIES];
  logic [TAG_W-1:0] t_tag  [ENTRIES];
  logic [HUGE_OFF-1:0] t_off [ENTRIES];
  logic signed [DLT_W-1:0] t_dlt [ENTRIES];
  logic [1:0]       t_conf [ENTRIES];

  logic            gran;
  logic [HUGE_OFF-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic            hit, match, zero, fire;
  logic signed [DLT_W-1:0] d;
  logic [1:0]      conf_nx;
  logic signed [CW-1:0] c1, c2, dx, lim;
  logic            in1, in2;
  logic [LA_W-1:0] base, l1, l2;

  logic            q_v    [2];
  logic [LA_W-1:0] q_line [2];

  assign gran = acc_huge & gran_sel;
  assign off  = gran ? acc_line[HUGE_OFF-1:0]
                     : {{(HUGE_OFF-SMALL_OFF){1'b0}}, acc_line[SMALL_OFF-1:0]};
  assign idx  = gran ? acc_line[HUGE_OFF+:IDX_W] : acc_line[SMALL_OFF+:IDX_W];
  assign tag  = gran ? acc_line[HUGE_OFF+IDX_W+:TAG_W] : acc_line[SMALL_OFF+IDX_W+:TAG_W];

  assign hit   = t_vld[idx] && (t_gran[idx] == gran) && (t_tag[idx] == tag);
  assign d     = $signed({1'b0, off}) - $signed({1'b0, t_off[idx]});
  assign zero  = (d == '0);
  assign match = (d == t_dlt[idx]);
  assign conf_nx = !match ? 2'd0 : (t_conf[idx] == 2'd3) ? 2'd3 : t_conf[idx] + 2'd1;
  assign fire  = acc_valid && hit && !zero && (conf_nx >= 2'd2);

  assign dx  = {{2{d[DLT_W-1]}}, d};
  assign c1  = $signed({3'b000, off}) + dx;
  assign c2  = c1 + dx;
  assign lim = gran ? CW'(1 << HUGE_OFF) : CW'(1 << SMALL_OFF);
  assign in1 = !c1[CW-1] && (c1 < lim);
  assign in2 = !c2[CW-1] && (c2 < lim);

  assign base = gran ? {acc_line[LA_W-1:HUGE_OFF], {HUGE_OFF{1'b0}}}
                     : {acc_line[LA_W-1:SMALL_OFF], {SMALL_OFF{1'b0}}};
  assign l1 = base | LA_W'(c1[HUGE_OFF-1:0]);
  assign l2 = base | LA_W'(c2[HUGE_OFF-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) t_vld[i] <= 1'b0;
    end else if (acc_valid) begin
      if (!hit) begin
        t_vld[idx]  <= 1'b1;
        t_gran[idx] <= gran;
        t_tag[idx]  <= tag;
        t_off[idx]  <= off;
        t_dlt[idx]  <= '0;
        t_conf[idx] <= 2'd0;
      end else if (!zero) begin
        t_off[idx]  <= off;
        t_dlt[idx]  <= d;
        t_conf[idx] <= conf_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      q_line[0] <= l1;
      q_line[1] <= l2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v[0] <= 1'b0;
      q_v[1] <= 1'b0;
    end else if (fire) begin
      q_v[0] <= in1;
      q_v[1] <= in2;
    end else if (pf_valid && pf_ready) begin
      if (q_v[0]) q_v[0] <= 1'b0;
      else        q_v[1] <= 1'b0;
    end
  end

  assign pf_valid = q_v[0] | q_v[1];
  assign pf_line  = q_v[0] ? q_line[0] : q_line[1];
endmodule

// File: rtl/ps_spatial_prefetch_chk.sv
module ps_spatial_prefetch_chk #(
  parameter int LA_W      = 34,
  parameter int SMALL_OFF = 6,
  parameter int HUGE_OFF  = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [LA_W-1:0] acc_line,
  input logic            acc_huge,
  input logic            gran_sel,
  input logic            pf_valid,
  input logic            pf_ready,
  input logic [LA_W-1:0] pf_line
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !pf_valid);

  p_no_spont_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid && !pf_valid |=> !pf_valid);

  p_page_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) && !$past(acc_huge && gran_sel) |->
      pf_line[LA_W-1:SMALL_OFF] == $past(acc_line[LA_W-1:SMALL_OFF]));

  p_huge_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) && $past(acc_huge && gran_sel) |->
      pf_line[LA_W-1:HUGE_OFF] == $past(acc_line[LA_W-1:HUGE_OFF]));

  p_zero_delta_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid) && acc_valid && acc_line == $past(acc_line) &&
    acc_huge == $past(acc_huge) && gran_sel == $past(gran_sel) && !pf_valid
      |=> !pf_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !acc_valid |=> pf_valid && $stable(pf_line));
endmodule

bind ps_spatial_prefetch ps_spatial_prefetch_chk #(
  .LA_W(LA_W), .SMALL_OFF(SMALL_OFF), .HUGE_OFF(HUGE_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
  .acc_huge(acc_huge), .gran_sel(gran_sel), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_line(pf_line)
);

// File: tb/tb_ps_spatial_prefetch.sv
module tb_ps_spatial_prefetch;
  logic        clk = 0, rst_n = 0, acc_valid = 0, acc_huge = 0, gran_sel = 0, pf_ready = 1;
  logic [33:0] acc_line = '0;
  logic        pf_valid;
  logic [33:0] pf_line;
  int          checks = 0, errors = 0;
  logic [33:0] exp_q[$];
  string       req_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  ps_spatial_prefetch dut (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
    .acc_huge(acc_huge), .gran_sel(gran_sel), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_line(pf_line));

  task automatic push(input logic [33:0] l, input string r);
    exp_q.push_back(l);
    req_q.push_back(r);
  endtask

  task automatic acc(input logic [33:0] l, input logic h, input logic s);
    @(negedge clk);
    acc_line = l; acc_huge = h; gran_sel = s; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic drained(input string r);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected prefetches missing, expected 0", r, exp_q.size());
      exp_q.delete(); req_q.delete();
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && pf_valid && pf_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected prefetch: actual %h expected none", pf_line);
        end else begin
          logic [33:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (pf_line !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, pf_line, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pf_valid !== 1'b0) begin errors++; $display("FAIL R1: actual %b expected 0", pf_valid); end
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 R4: basic training and ordering
    acc(34'h1000, 0, 1); acc(34'h1002, 0, 1); acc(34'h1004, 0, 1);
    push(34'h1008, "R4"); push(34'h100A, "R4");
    acc(34'h1006, 0, 1);
    push(34'h100A, "R3"); push(34'h100C, "R3");
    acc(34'h1008, 0, 1);
    drained("R3");

    // R5: 4KB clamp, positive and negative stride
    acc(34'h202C, 0, 1); acc(34'h2030, 0, 1); acc(34'h2034, 0, 1);
    push(34'h203C, "R5");
    acc(34'h2038, 0, 1);
    drained("R5");
    acc(34'h3014, 0, 1); acc(34'h300F, 0, 1); acc(34'h300A, 0, 1);
    push(34'h3000, "R5");
    acc(34'h3005, 0, 1);
    drained("R5");

    // R2: huge tag but granularity select off -> 4KB clamp
    acc(34'h402C, 1, 0); acc(34'h4030, 1, 0); acc(34'h4034, 1, 0);
    push(34'h403C, "R2");
    acc(34'h4038, 1, 0);
    drained("R2");

    // R6 R7: 2MB region, stride of one 4KB frame
    acc(34'h8000, 1, 1); acc(34'h8040, 1, 1); acc(34'h8080, 1, 1);
    push(34'h8100, "R7"); push(34'h8140, "R6");
    acc(34'h80C0, 1, 1);
    drained("R7");

    // R6: 2MB boundary clamp
    acc(34'h10000 + 32300, 1, 1); acc(34'h10000 + 32400, 1, 1); acc(34'h10000 + 32500, 1, 1);
    push(34'h17FBC, "R6");
    acc(34'h10000 + 32600, 1, 1);
    drained("R6");

    // R9: zero delta leaves state unchanged
    acc(34'h5000, 0, 1); acc(34'h5003, 0, 1); acc(34'h5006, 0, 1);
    acc(34'h5006, 0, 1);
    drained("R9");
    push(34'h500C, "R9"); push(34'h500F, "R9");
    acc(34'h5009, 0, 1);
    drained("R9");

    // R10: mismatch resets confidence
    acc(34'h6000, 0, 1); acc(34'h6002, 0, 1); acc(34'h6004, 0, 1);
    acc(34'h6007, 0, 1); acc(34'h600A, 0, 1);
    drained("R10");
    push(34'h6010, "R10"); push(34'h6013, "R10");
    acc(34'h600D, 0, 1);
    drained("R10");

    // R12: tag mismatch at same index reallocates
    acc(34'h7000, 0, 1); acc(34'h7002, 0, 1); acc(34'h7004, 0, 1);
    acc(34'h17006, 0, 1); acc(34'h7006, 0, 1);
    drained("R12");

    // R8: granularity mismatch on shared slot reallocates
    acc(34'h628000, 1, 1); acc(34'h628001, 1, 1); acc(34'h628002, 1, 1);
    acc(34'h3143, 0, 1);
    drained("R8");
    acc(34'h3144, 0, 1); acc(34'h3145, 0, 1);
    push(34'h3147, "R8"); push(34'h3148, "R8");
    acc(34'h3146, 0, 1);
    drained("R8");

    // R11: backpressure hold and replacement
    @(negedge clk); pf_ready = 0;
    acc(34'h9000, 0, 1); acc(34'h9001, 0, 1); acc(34'h9002, 0, 1); acc(34'h9003, 0, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      checks++;
      if (pf_valid !== 1'b1 || pf_line !== 34'h9004) begin
        errors++;
        $display("FAIL R11: actual %b/%h expected 1/%h", pf_valid, pf_line, 34'h9004);
      end
    end
    push(34'h9005, "R11"); push(34'h9006, "R11");
    acc(34'h9004, 0, 1);
    @(negedge clk); pf_ready = 1;
    repeat (4) @(negedge clk);
    drained("R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule